// File: doc/BRIEF.md
# Programmable Delay-Timer Conversion Scheduler

This block holds a small bank of delay timers that pace analog conversions. Each timer counts a slow strobe (nominally 2000 per second) delivered on `tick_i`. When a timer runs out, it sends one start pulse to each conversion slot named in its slot mask, and it can restart any timer named in its restart mask, itself included. A loop field repeats the period a fixed number of times without any further help from software. After the last period the timer's run bit drops by itself and a one-cycle completion pulse is raised.

Software reaches each timer through a single 32-bit control word. A write port offers plain write, bit-set and bit-clear access, and a read port returns any word at once. Setting the run bit starts a timer, clearing it stops the timer. Each timer is a two-state machine: `T_IDLE` (not counting) and `T_WAIT` (counting ticks). The transitions are: start (`T_IDLE` or `T_WAIT` to `T_WAIT`, loading the delay and loop fields), reload (`T_WAIT` to `T_WAIT` at an expiry with loops left), finish (`T_WAIT` to `T_IDLE` at the last expiry) and abort (`T_WAIT` to `T_IDLE` when the run bit is cleared).

Top module: `delay_sched`

## Requirements
- R1: After reset every control word reads 0, and `slot_go_o` and `done_o` are 0.
- R2: A write with `wr_op_i` = 0 replaces the word of timer `wr_idx_i`, 1 ORs `wr_data_i` into it, 2 clears the bits set in `wr_data_i`, and 3 leaves it unchanged; `rd_data_o` shows the word of timer `rd_idx_i` in the same cycle.
- R3: Word layout: delay in bits 10:0, loop count in bits 15:11, restart mask in bits 19:16 (bit k names timer k), run bit at bit 20, slot mask in bits 31:24 (bit s names slot s); bits 23:21 are plain storage.
- R4: A run-bit transition from 0 to 1 starts the timer; its first expiry occurs on the max(D,1)-th tick after the start cycle, where D is the delay, and `slot_go_o` carries the slot mask in the cycle after that tick.
- R5: A loop count L gives L+1 expiries, each max(D,1) ticks after the previous one.
- R6: At the final expiry the run bit reads 0 from the next cycle and `done_o[k]` pulses together with that expiry's slot pulse.
- R7: Clearing the run bit while counting stops the timer: no later slot pulse and no completion pulse.
- R8: An expiry restarts every timer in its restart mask (setting its run bit, reloading it even if running); a timer restarted by its own final expiry keeps its run bit and gives no completion pulse.
- R9: Timers expiring on the same tick have their slot masks ORed on `slot_go_o`.
- R10: Setting the run bit of a timer that is already running has no effect on its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe of the slow timing tick |
| wr_en_i | input | 1 | Write strobe |
| wr_op_i | input | 2 | Access kind: 0 write, 1 set, 2 clear, 3 none |
| wr_idx_i | input | 2 | Timer addressed by the write |
| wr_data_i | input | 32 | Write data or bit mask |
| rd_idx_i | input | 2 | Timer whose word is read |
| rd_data_o | output | 32 | Control word of timer `rd_idx_i` |
| slot_go_o | output | 8 | Per-slot conversion start pulses |
| done_o | output | 4 | Per-timer completion pulses |

## Verification
The scheduler is driven with a single one-shot timer, a looping timer with a short period, a timer aborted mid-count, a chain where one expiry restarts another timer, a self-restarting timer, two timers expiring on the same tick, and a redundant set of a running run bit. The one-shot and looping cases separate the first-period count from the reload count, the abort and redundant-set cases separate edge starts from level starts, and the chain and self-restart cases settle the priority between the automatic run-bit clear and a restart. Every access kind is also tried on words with the run bit held low, so that storage is checked apart from counting.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } reg_op_e;

    typedef enum logic {
        T_IDLE = 1'b0,
        T_WAIT = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/dsch_timer.sv
module dsch_timer
    import dsch_pkg::*;
#(
    parameter int DLY_W  = 11,
    parameter int LOOP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [DLY_W-1:0]  dly_i,
    input  logic [LOOP_W-1:0] loop_i,
    output logic              expire_o,
    output logic              final_o
);
    tmr_state_e        st_q, st_d;
    logic [DLY_W-1:0]  cnt_q, cnt_d;
    logic [LOOP_W-1:0] lp_q, lp_d;
    logic              at_end;

    assign at_end = (cnt_q <= DLY_W'(1));

    // outputs
    always_comb begin
        expire_o = (st_q == T_WAIT) && tick_i && at_end;
        final_o  = expire_o && (lp_q == '0);
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lp_d  = lp_q;
        if (start_i) begin
            st_d  = T_WAIT;
            cnt_d = dly_i;
            lp_d  = loop_i;
        end else begin
            unique case (st_q)
                T_IDLE: ;
                T_WAIT: begin
                    if (stop_i) begin
                        st_d = T_IDLE;
                    end else if (tick_i) begin
                        if (at_end) begin
                            if (lp_q == '0) begin
                                st_d = T_IDLE;
                            end else begin
                                lp_d  = lp_q - LOOP_W'(1);
                                cnt_d = dly_i;
                            end
                        end else begin
                            cnt_d = cnt_q - DLY_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= T_IDLE;
            cnt_q <= '0;
            lp_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lp_q  <= lp_d;
        end
    end
endmodule

// File: rtl/dsch_regs.sv
module dsch_regs
    import dsch_pkg::*;
#(
    parameter int N_TMR    = 4,
    parameter int REG_W    = 32,
    parameter int KICK_BIT = 20,
    localparam int IDX_W   = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [1:0]                   wr_op_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  logic [REG_W-1:0]             wr_data_i,
    input  logic [N_TMR-1:0]             hw_clr_i,
    input  logic [N_TMR-1:0]             hw_set_i,
    output logic [N_TMR-1:0][REG_W-1:0]  sw_view_o,
    output logic [N_TMR-1:0][REG_W-1:0]  reg_q_o,
    output logic [N_TMR-1:0]             kick_d_o,
    output logic [N_TMR-1:0]             kick_rise_o
);
    logic [N_TMR-1:0][REG_W-1:0] reg_d;

    for (genvar i = 0; i < N_TMR; i++) begin : g_word
        always_comb begin
            sw_view_o[i] = reg_q_o[i];
            if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
                case (reg_op_e'(wr_op_i))
                    OP_WRITE: sw_view_o[i] = wr_data_i;
                    OP_SET:   sw_view_o[i] = reg_q_o[i] | wr_data_i;
                    OP_CLEAR: sw_view_o[i] = reg_q_o[i] & ~wr_data_i;
                    default:  sw_view_o[i] = reg_q_o[i];
                endcase
            end
        end

        // hardware restart wins over the automatic clear and over software
        assign kick_d_o[i]    = (sw_view_o[i][KICK_BIT] & ~hw_clr_i[i]) | hw_set_i[i];
        assign kick_rise_o[i] = sw_view_o[i][KICK_BIT] & ~reg_q_o[i][KICK_BIT];

        always_comb begin
            reg_d[i]           = sw_view_o[i];
            reg_d[i][KICK_BIT] = kick_d_o[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_q_o[i] <= '0;
            else        reg_q_o[i] <= reg_d[i];
        end
    end
endmodule

// File: rtl/dsch_fanout.sv
module dsch_fanout #(
    parameter int N_TMR  = 4,
    parameter int SLOT_W = 8
) (
    input  logic [N_TMR-1:0]              expire_i,
    input  logic [N_TMR-1:0][SLOT_W-1:0]  slot_mask_i,
    input  logic [N_TMR-1:0][N_TMR-1:0]   rtg_mask_i,
    output logic [SLOT_W-1:0]             slot_or_o,
    output logic [N_TMR-1:0]              rtg_hit_o
);
    always_comb begin
        slot_or_o = '0;
        rtg_hit_o = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (expire_i[i]) begin
                slot_or_o = slot_or_o | slot_mask_i[i];
                rtg_hit_o = rtg_hit_o | rtg_mask_i[i];
            end
        end
    end
endmodule

// File: rtl/delay_sched.sv
module delay_sched
    import dsch_pkg::*;
#(
    parameter int N_TMR  = 4,
    parameter int DLY_W  = 11,
    parameter int LOOP_W = 5,
    parameter int SLOT_W = 8,
    parameter int REG_W  = 32,
    localparam int IDX_W    = (N_TMR > 1) ? $clog2(N_TMR) : 1,
    localparam int LOOP_LO  = DLY_W,
    localparam int RTG_LO   = LOOP_LO + LOOP_W,
    localparam int KICK_BIT = RTG_LO + N_TMR,
    localparam int SLOT_LO  = REG_W - SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_op_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic [SLOT_W-1:0] slot_go_o,
    output logic [N_TMR-1:0]  done_o
);
    logic [N_TMR-1:0][REG_W-1:0]  sw_view, reg_q;
    logic [N_TMR-1:0][SLOT_W-1:0] slot_mask;
    logic [N_TMR-1:0][N_TMR-1:0]  rtg_mask;
    logic [N_TMR-1:0] kick_d, kick_rise, kick_q;
    logic [N_TMR-1:0] expire, fin, rtg_hit, hw_clr, start, stop;
    logic [SLOT_W-1:0] slot_or;

    assign hw_clr = fin & ~rtg_hit;
    assign start  = rtg_hit | kick_rise;
    assign stop   = ~kick_d;

    dsch_regs #(.N_TMR(N_TMR), .REG_W(REG_W), .KICK_BIT(KICK_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_op_i(wr_op_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .hw_clr_i(hw_clr), .hw_set_i(rtg_hit),
        .sw_view_o(sw_view), .reg_q_o(reg_q),
        .kick_d_o(kick_d), .kick_rise_o(kick_rise)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        assign slot_mask[i] = sw_view[i][SLOT_LO +: SLOT_W];
        assign rtg_mask[i]  = sw_view[i][RTG_LO +: N_TMR];
        assign kick_q[i]    = reg_q[i][KICK_BIT];

        dsch_timer #(.DLY_W(DLY_W), .LOOP_W(LOOP_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
            .start_i(start[i]), .stop_i(stop[i]),
            .dly_i(sw_view[i][DLY_W-1:0]),
            .loop_i(sw_view[i][LOOP_LO +: LOOP_W]),
            .expire_o(expire[i]), .final_o(fin[i])
        );
    end

    dsch_fanout #(.N_TMR(N_TMR), .SLOT_W(SLOT_W)) u_fan (
        .expire_i(expire), .slot_mask_i(slot_mask), .rtg_mask_i(rtg_mask),
        .slot_or_o(slot_or), .rtg_hit_o(rtg_hit)
    );

    assign rd_data_o = reg_q[rd_idx_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_go_o <= '0;
            done_o    <= '0;
        end else begin
            slot_go_o <= slot_or;
            done_o    <= hw_clr;
        end
    end
endmodule

// File: rtl/dsch_chk.sv
module dsch_chk #(
    parameter int N_TMR    = 4,
    parameter int SLOT_W   = 8,
    parameter int REG_W    = 32,
    parameter int IDX_W    = 2,
    parameter int KICK_BIT = 20
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick_i,
    input logic                        wr_en_i,
    input logic [1:0]                  wr_op_i,
    input logic [IDX_W-1:0]            wr_idx_i,
    input logic [REG_W-1:0]            wr_data_i,
    input logic [SLOT_W-1:0]           slot_go_o,
    input logic [N_TMR-1:0]            done_o,
    input logic [N_TMR-1:0]            kick_q,
    input logic [N_TMR-1:0][REG_W-1:0] reg_q
);
    localparam logic [REG_W-1:0] KMASK = REG_W'(1) << KICK_BIT;

    AST_FIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) (slot_go_o != '0) |-> $past(tick_i)); // R4
    AST_DONE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) (done_o != '0) |-> $past(tick_i)); // R6
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_i && wr_op_i == 2'd0 && wr_idx_i == '0) |=> ((reg_q[0] & ~KMASK) == ($past(wr_data_i) & ~KMASK))); // R2
    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_i && wr_op_i == 2'd2 && wr_idx_i == '0) |=> ((reg_q[0] & $past(wr_data_i) & ~KMASK) == '0)); // R2

    for (genvar k = 0; k < N_TMR; k++) begin : g_k
        AST_DONE_DROPS_KICK: assert property (@(posedge clk) disable iff (!rst_n) done_o[k] |-> !kick_q[k]); // R6
    end
endmodule

bind delay_sched dsch_chk #(
    .N_TMR(N_TMR), .SLOT_W(SLOT_W), .REG_W(REG_W), .IDX_W(IDX_W), .KICK_BIT(KICK_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_op_i(wr_op_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .slot_go_o(slot_go_o), .done_o(done_o), .kick_q(kick_q), .reg_q(reg_q)
);

// File: tb/tb_delay_sched.sv
`timescale 1ns/1ps
module tb_delay_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_op_i = 2'd0;
    logic [1:0]  wr_idx_i = 2'd0;
    logic [31:0] wr_data_i = '0;
    logic [1:0]  rd_idx_i = 2'd0;
    logic [31:0] rd_data_o;
    logic [7:0]  slot_go_o;
    logic [3:0]  done_o;

    delay_sched dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_op_i(wr_op_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
        .slot_go_o(slot_go_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    tick_en = 0;
    int    tphase = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_reg [4];
    int          m_st [4];
    int          m_cnt [4];
    int          m_lp [4];
    logic [7:0]  m_slot;
    logic [3:0]  m_done;

    task automatic model_step();
        logic [31:0] sw [4];
        bit          ex [4];
        bit          fi [4];
        logic [3:0]  hit;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_reg[i] = '0; m_st[i] = 0; m_cnt[i] = 0; m_lp[i] = 0;
            end
            m_slot = '0; m_done = '0;
            return;
        end
        for (int i = 0; i < 4; i++) begin
            sw[i] = m_reg[i];
            if (wr_en_i && wr_idx_i == 2'(i)) begin
                if (wr_op_i == 2'd0) sw[i] = wr_data_i;
                else if (wr_op_i == 2'd1) sw[i] = m_reg[i] | wr_data_i;
                else if (wr_op_i == 2'd2) sw[i] = m_reg[i] & ~wr_data_i;
            end
            ex[i] = (m_st[i] == 1) && tick_i && (m_cnt[i] <= 1);
            fi[i] = ex[i] && (m_lp[i] == 0);
        end
        m_slot = '0; hit = '0;
        for (int i = 0; i < 4; i++)
            if (ex[i]) begin
                m_slot |= sw[i][31:24];
                hit    |= sw[i][19:16];
            end
        m_done = '0;
        for (int i = 0; i < 4; i++) begin
            bit kick, rise;
            kick = sw[i][20];
            rise = kick && !m_reg[i][20];
            if (fi[i] && !hit[i]) begin
                kick = 0;
                m_done[i] = 1'b1;
            end
            if (hit[i]) kick = 1;
            m_reg[i] = sw[i];
            m_reg[i][20] = kick;
            if (hit[i] || rise) begin
                m_st[i] = 1; m_cnt[i] = int'(sw[i][10:0]); m_lp[i] = int'(sw[i][15:11]);
            end else if (!kick) begin
                m_st[i] = 0;
            end else if (m_st[i] == 1 && tick_i) begin
                if (m_cnt[i] <= 1) begin
                    if (m_lp[i] == 0) m_st[i] = 0;
                    else begin m_lp[i]--; m_cnt[i] = int'(sw[i][10:0]); end
                end else m_cnt[i]--;
            end
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #2;
        n_cmp++;
        if (slot_go_o !== m_slot) begin
            n_bad++;
            $display("FAIL %s slot_go cyc %0d: got %h exp %h", cur_req, cyc, slot_go_o, m_slot);
        end
        n_cmp++;
        if (done_o !== m_done) begin
            n_bad++;
            $display("FAIL %s done cyc %0d: got %h exp %h", cur_req, cyc, done_o, m_done);
        end
        n_cmp++;
        if (rd_data_o !== m_reg[rd_idx_i]) begin
            n_bad++;
            $display("FAIL %s rd_data[%0d] cyc %0d: got %h exp %h", cur_req, rd_idx_i, cyc, rd_data_o, m_reg[rd_idx_i]);
        end
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
            report();
        end
    end

    // tick strobe and rotating read index
    always @(negedge clk) begin
        tick_i   <= tick_en && (tphase % 3 == 0);
        tphase   <= tphase + 1;
        rd_idx_i <= rd_idx_i + 2'd1;
    end

    task automatic wr(input logic [1:0] op, input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_op_i = op; wr_idx_i = idx; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [31:0] KICK = 32'h0010_0000;

    initial begin
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(6);

        // R2 R3: access kinds with run bit low
        cur_req = "R2";
        wr(2'd0, 2'd1, 32'hA5A0_F3C7);
        wr(2'd1, 2'd1, 32'h0008_0001);
        wr(2'd2, 2'd1, 32'h0000_0003);
        wr(2'd3, 2'd1, 32'hFFEF_FFFF);
        cur_req = "R3";
        wr(2'd0, 2'd2, 32'h5A0F_0C38);
        wr(2'd1, 2'd3, 32'h00E0_0000);
        idle(6);
        wr(2'd0, 2'd1, 32'h0); wr(2'd0, 2'd2, 32'h0); wr(2'd0, 2'd3, 32'h0);

        tick_en = 1;
        // R4 R6: one-shot
        cur_req = "R4";
        wr(2'd0, 2'd0, 32'h0100_0003 | KICK);
        idle(20);
        cur_req = "R6";
        wr(2'd0, 2'd0, 32'h0100_0000 | KICK);
        idle(12);
        // R5: looping timer
        cur_req = "R5";
        wr(2'd0, 2'd1, 32'h0200_1802 | KICK);
        idle(40);
        // R7: abort mid-count
        cur_req = "R7";
        wr(2'd0, 2'd2, 32'h0400_3805 | KICK);
        idle(14);
        wr(2'd2, 2'd2, KICK);
        idle(30);
        // R8: chain and self restart
        cur_req = "R8";
        wr(2'd0, 2'd2, 32'h2000_0801);
        wr(2'd0, 2'd0, 32'h1004_0002 | KICK);
        idle(30);
        wr(2'd0, 2'd3, 32'h8008_0001 | KICK);
        idle(25);
        wr(2'd2, 2'd3, KICK);
        idle(12);
        // R9: simultaneous expiry
        cur_req = "R9";
        tick_en = 0;
        idle(3);
        wr(2'd0, 2'd0, 32'h0100_0002 | KICK);
        wr(2'd0, 2'd1, 32'h0200_0002 | KICK);
        tick_en = 1;
        idle(20);
        // R10: redundant set of running timer
        cur_req = "R10";
        wr(2'd0, 2'd1, 32'h4000_0004 | KICK);
        idle(7);
        wr(2'd1, 2'd1, KICK);
        idle(25);
        report();
    end
endmodule